// File: doc/BRIEF.md
# Dual-Channel Switch Command Selector

This block produces the gate-enable command for each of two power switch channels. Each cycle it looks at the operating state that the surrounding device reports and at the variant strap. From these it picks the source of each channel's command. In the register variant the source is a software enable bit or a limp-home bit. In the pin variant the source is a direct input pin. In the off states the command is forced low, and in the two low-power states the current command is frozen.

The direct input pins are asynchronous to the block clock. They pass through a two-stage synchronizer before they are used. The gate enables come from registers, so any change in the state or a register bit reaches the outputs one clock edge later. The block has no data stream, so every pin is a plain control level. State sequencing, register storage, protection overrides and the analog gate drive all sit outside this block.

Top module: `sw_cmd_top`

## Requirements
- R1: `op_state` is coded as 0 SLEEP, 1 CONFIG, 2 ACTIVE, 3 LIMP_HOME, 4 AUTO_LPM, 5 MANUAL_LPM, 6 VBB_WRN, 7 VBB_UVLO. Bit 0 of every channel vector is channel 1 and bit 1 is channel 2. `pin_mode` = 0 selects the register variant and `pin_mode` = 1 selects the pin variant.
- R2: While `rst_n` is low, `gate_en` is 00.
- R3: One edge after `op_state` is SLEEP (0) or VBB_UVLO (7), `gate_en` is 00 in both variants, whatever the other inputs are.
- R4: One edge after `op_state` is CONFIG (1), `gate_en` is 00.
- R5: In the register variant, one edge after `op_state` is ACTIVE (2) or VBB_WRN (6), `gate_en` equals `reg_on` as sampled at that edge.
- R6: In the pin variant, in ACTIVE (2) or VBB_WRN (6), `gate_en` follows the synchronized `dir_in`, and `reg_on` has no effect.
- R7: In the register variant, one edge after `op_state` is LIMP_HOME (3), `gate_en` equals `limp_on`.
- R8: In the pin variant, LIMP_HOME (3) is illegal, and one edge later `gate_en` is 00.
- R9: When `op_state` enters AUTO_LPM (4) or MANUAL_LPM (5) from any other state, `gate_en` keeps the value it had just before entry. It holds that value for as long as the state stays in {4,5}, and all data inputs are ignored.
- R10: A direct move between AUTO_LPM and MANUAL_LPM keeps the value that was held. It does not capture a new one.
- R11: In the pin variant, a change on `dir_in` set up before clock edge k first appears on `gate_en` after edge k+2, which is the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_state | input | 3 | Encoded operating state (R1) |
| pin_mode | input | 1 | Variant strap: 0 register, 1 pin |
| reg_on | input | 2 | Per-channel software enable bits |
| limp_on | input | 2 | Per-channel limp-home bits |
| dir_in | input | 2 | Asynchronous direct control pins |
| gate_en | output | 2 | Registered per-channel gate enables |

## Verification
The assertions assume that `op_state`, `pin_mode`, `reg_on` and `limp_on` are synchronous to `clk`. They also assume that `pin_mode` is a strap that never changes while the block is out of reset. To respect this, the bench drives every input only at falling edges and picks `pin_mode` once per reset episode. Random states are held for runs of several cycles so that low-power entry, low-power-to-low-power moves and the pin latency all occur often. A reference model written from the requirements predicts `gate_en` for every cycle.

// File: rtl/sw_cmd_pkg.sv
package sw_cmd_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP  = 3'd0,
    ST_CONFIG = 3'd1,
    ST_ACTIVE = 3'd2,
    ST_LIMP   = 3'd3,
    ST_ALPM   = 3'd4,
    ST_MLPM   = 3'd5,
    ST_WARN   = 3'd6,
    ST_UVLO   = 3'd7
  } opstate_e;

  function automatic logic is_lowpwr(input logic [2:0] st);
    return (st == ST_ALPM) || (st == ST_MLPM);
  endfunction

  function automatic logic is_run(input logic [2:0] st);
    return (st == ST_ACTIVE) || (st == ST_WARN);
  endfunction

endpackage

// File: rtl/sw_pin_sync.sv
module sw_pin_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/sw_lp_hold.sv
module sw_lp_hold
  import sw_cmd_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_state,
  input  logic [WIDTH-1:0] cur_cmd,
  output logic [WIDTH-1:0] hold_val
);
  logic             in_lp_q;
  logic [WIDTH-1:0] held_q;
  logic             entering;

  assign entering = is_lowpwr(op_state) && !in_lp_q;
  assign hold_val = entering ? cur_cmd : held_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_lp_q <= 1'b0;
      held_q  <= '0;
    end else begin
      in_lp_q <= is_lowpwr(op_state);
      if (entering) held_q <= cur_cmd;
    end
  end

  // R10: staying inside the low-power set never reloads the held value
  p_held_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_lp_q && is_lowpwr(op_state)) |=> $stable(held_q));
endmodule

// File: rtl/sw_cmd_select.sv
module sw_cmd_select
  import sw_cmd_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic [2:0]       op_state,
  input  logic             pin_mode,
  input  logic [WIDTH-1:0] reg_on,
  input  logic [WIDTH-1:0] limp_on,
  input  logic [WIDTH-1:0] pin_val,
  input  logic [WIDTH-1:0] hold_val,
  output logic [WIDTH-1:0] next_cmd
);
  always_comb begin
    next_cmd = '0;
    unique case (op_state)
      ST_ACTIVE, ST_WARN: next_cmd = pin_mode ? pin_val : reg_on;
      ST_LIMP:            next_cmd = pin_mode ? '0 : limp_on;
      ST_ALPM, ST_MLPM:   next_cmd = hold_val;
      default:            next_cmd = '0;
    endcase
  end
endmodule

// File: rtl/sw_cmd_top.sv
module sw_cmd_top
  import sw_cmd_pkg::*;
#(
  parameter int CH_COUNT    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2:0]          op_state,
  input  logic                pin_mode,
  input  logic [CH_COUNT-1:0] reg_on,
  input  logic [CH_COUNT-1:0] limp_on,
  input  logic [CH_COUNT-1:0] dir_in,
  output logic [CH_COUNT-1:0] gate_en
);
  localparam logic [CH_COUNT-1:0] ALL_OFF = '0;

  logic [CH_COUNT-1:0] pin_val;
  logic [CH_COUNT-1:0] hold_val;
  logic [CH_COUNT-1:0] next_cmd;

  sw_pin_sync #(.WIDTH(CH_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(dir_in), .dout(pin_val)
  );

  sw_lp_hold #(.WIDTH(CH_COUNT)) u_hold (
    .clk(clk), .rst_n(rst_n), .op_state(op_state),
    .cur_cmd(gate_en), .hold_val(hold_val)
  );

  sw_cmd_select #(.WIDTH(CH_COUNT)) u_sel (
    .op_state(op_state), .pin_mode(pin_mode), .reg_on(reg_on),
    .limp_on(limp_on), .pin_val(pin_val), .hold_val(hold_val),
    .next_cmd(next_cmd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_en <= ALL_OFF;
    else        gate_en <= next_cmd;
  end

  // R3
  p_off_states_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == ST_SLEEP || op_state == ST_UVLO) |=> gate_en == ALL_OFF);
  // R4
  p_config_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == ST_CONFIG) |=> gate_en == ALL_OFF);
  // R5
  p_reg_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_mode && is_run(op_state)) |=> gate_en == $past(reg_on));
  // R7
  p_limp_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_mode && op_state == ST_LIMP) |=> gate_en == $past(limp_on));
  // R8
  p_limp_pin_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_mode && op_state == ST_LIMP) |=> gate_en == ALL_OFF);
  // R9
  p_lp_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_lowpwr(op_state) |=> $stable(gate_en));
endmodule

// File: tb/sw_cmd_top_test.sv
`timescale 1ns/1ps
module sw_cmd_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_state = 3'd0;
  logic       pin_mode = 1'b0;
  logic [1:0] reg_on = 2'b00, limp_on = 2'b00, dir_in = 2'b00;
  logic [1:0] gate_en;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sw_cmd_top uut (
    .clk(clk), .rst_n(rst_n), .op_state(op_state), .pin_mode(pin_mode),
    .reg_on(reg_on), .limp_on(limp_on), .dir_in(dir_in), .gate_en(gate_en)
  );

  function automatic bit lp(input logic [2:0] s);
    return s == 3'd4 || s == 3'd5;
  endfunction

  // expected next command from requirements R3..R8
  function automatic logic [1:0] ref_cmd(input logic [2:0] s, input logic pm,
      input logic [1:0] r, input logic [1:0] l, input logic [1:0] p);
    if (s == 3'd2 || s == 3'd6) return pm ? p : r;
    if (s == 3'd3) return pm ? 2'b00 : l;
    return 2'b00;
  endfunction

  function automatic string tag_of(input logic [2:0] s, input logic [2:0] ps,
      input logic pm);
    case (s)
      3'd0, 3'd7: return "R3 R1";
      3'd1: return "R4 R1";
      3'd2, 3'd6: return pm ? "R6 R1" : "R5 R1";
      3'd3: return pm ? "R8 R1" : "R7 R1";
      default: return (lp(ps) && ps != s) ? "R10 R1" : "R9 R1";
    endcase
  endfunction

  logic [1:0] m_s1, m_s2, m_gate;
  logic [2:0] m_prev;
  string m_tag = "R2";

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 2'b00; m_s2 <= 2'b00; m_gate <= 2'b00;
      m_prev <= 3'd0; m_tag <= "R2";
    end else begin
      m_s1 <= dir_in; m_s2 <= m_s1; m_prev <= op_state;
      m_tag <= tag_of(op_state, m_prev, pin_mode);
      if (!lp(op_state)) m_gate <= ref_cmd(op_state, pin_mode, reg_on, limp_on, m_s2);
    end
  end

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: gate_en=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick_check();
    @(posedge clk); @(negedge clk);
    check(m_tag, gate_en, m_gate);
  endtask

  task automatic do_reset(input logic pm);
    @(negedge clk);
    rst_n = 1'b0; pin_mode = pm; op_state = 3'd2; reg_on = 2'b11; dir_in = 2'b11;
    #1 check("R2", gate_en, 2'b00);
    @(negedge clk); check("R2", gate_en, 2'b00);
    op_state = 3'd0; reg_on = 2'b00; dir_in = 2'b00;
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd1234));
    // directed: register variant, hold across LP -> LP
    do_reset(1'b0);
    op_state = 3'd2; reg_on = 2'b01; tick_check();
    check("R5", gate_en, 2'b01);
    op_state = 3'd4; reg_on = 2'b10; tick_check();
    check("R9", gate_en, 2'b01);
    op_state = 3'd5; reg_on = 2'b11; limp_on = 2'b11; tick_check();
    check("R10", gate_en, 2'b01);
    tick_check(); check("R10", gate_en, 2'b01);
    op_state = 3'd3; limp_on = 2'b10; tick_check();
    check("R7", gate_en, 2'b10);
    op_state = 3'd1; tick_check(); check("R4", gate_en, 2'b00);

    // directed: pin variant latency and illegal limp
    do_reset(1'b1);
    op_state = 3'd2; reg_on = 2'b11; dir_in = 2'b00;
    repeat (3) tick_check();
    check("R6", gate_en, 2'b00);
    dir_in = 2'b10;
    tick_check(); check("R11", gate_en, 2'b00);
    tick_check(); check("R11", gate_en, 2'b00);
    tick_check(); check("R11", gate_en, 2'b10);
    op_state = 3'd3; limp_on = 2'b11; tick_check();
    check("R8", gate_en, 2'b00);
    op_state = 3'd6; dir_in = 2'b01; repeat (3) tick_check();
    check("R6", gate_en, 2'b01);
    op_state = 3'd7; tick_check(); check("R3", gate_en, 2'b00);

    // random runs
    for (int ep = 0; ep < 8; ep++) begin
      do_reset(ep[0]);
      for (int run = 0; run < 150; run++) begin
        op_state = 3'($urandom_range(0, 7));
        for (int c = 0; c < int'($urandom_range(1, 6)); c++) begin
          reg_on = 2'($urandom); limp_on = 2'($urandom); dir_in = 2'($urandom);
          tick_check();
        end
      end
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule